// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Engine

This block lives inside a PCIe endpoint. It turns single-cycle internal event pulses into message write requests. A host reaches a table of per-vector entries through a small memory-mapped register port behind one BAR window. Each entry holds a 64-bit message address, a 32-bit message data word and a vector control word whose bit 0 is the mask. A read-only bit array at a fixed, parameterised offset in the same window shows which vectors still owe a message. Each 64-bit word of that array covers 64 consecutive vectors, and bit i of word w belongs to vector 64*w+i.

Every accepted event sets its vector's owed bit. A fixed lowest-index-first arbiter then picks among owed vectors whose mask is clear, but only while the enable input is high and the function-mask input is low. The chosen vector's address and data are copied into an output register. The owed bit clears in that same cycle. The output is valid/ready: once `msg_valid` is high, address, data and vector number stay unchanged until a cycle in which `msg_ready` is high. A new request may load in that same cycle. The data word is sent unchanged, and its low 8 bits carry the interrupt vector number the host uses. Events never stall, because a repeat event for an owed vector merges into its existing bit.

Host writes take effect at the clock edge where `host_wr_en` is high. Read data appears on `host_rdata` after the edge where `host_rd_en` is high, and it holds until the next read. The offset of the owed-bit array must lie above the end of the table.

Top module: `msix_engine`

## Requirements
- R1: After reset, `msg_valid` is 0, every vector control word reads 1 (masked), and every word of the owed-bit array reads 0.
- R2: The entry for vector v lies at byte offset 16*v. Message address low is at +0x0, message address high at +0x4, message data at +0x8, and vector control at +0xC. The first three read back exactly as written. Vector control keeps only bit 0 and reads 0 in bits 31:1.
- R3: An event for an unmasked vector, with enable high and function mask low, is sampled at edge k. It raises `msg_valid` after edge k+1, carrying {high,low} as the address, the data word unchanged, and v as the vector.
- R4: An event for a masked vector sends no message. It sets bit v%64 of owed word v/64. That word's low half reads at byte offset PBA_OFF+8*(v/64), and its high half at +4.
- R5: Writing 0 to the mask of a vector whose owed bit is set sends that vector's message without a further event, and the owed bit then reads 0.
- R6: While the function mask is high or the enable is low, no message is loaded. Events still set owed bits, and the owed messages are sent once the enable is high, the function mask is low and the vector mask is clear.
- R7: When several vectors are eligible, they are sent in ascending vector order.
- R8: While `msg_valid` is high and `msg_ready` is low, the message fields stay stable. Each owed vector yields exactly one message.
- R9: A further event for a vector whose owed bit is already set merges into that bit and produces no second message.
- R10: Host writes to the owed-bit array are ignored. Reads of addresses that are neither in the table nor in the array return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Byte address within the BAR window (dword aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| evt_valid | input | 1 | Event pulse |
| evt_vec | input | VW | Vector number of the event |
| vec_enable | input | 1 | Global enable for sending |
| func_mask | input | 1 | Function-wide mask; holds back all sends |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data word |
| msg_vec | output | VW | Vector number of the message |

## Verification
Every vector of a 72-vector configuration is first fired one at a time while unmasked. The bench compares each message with address and data values it computes from the vector number, which tells apart wrong table indexing or swapped address halves. Next, a scattered set of masked vectors crossing the 64-bit word boundary is fired, including a repeat event. The owed-bit words are read back and one vector is unmasked alone, which separates set, merge and replay-on-unmask behaviour. Last, several vectors are owed behind the function mask and the enable, then released under back-pressure. This exposes arbitration order, stability while stalled and the count of messages.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int ENTRY_BYTES = 16;
  localparam int QW_BITS     = 64;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msix_msg_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VW-1:0]      wr_idx,
  input  logic [1:0]         wr_dw,
  input  logic [31:0]        wr_data,
  input  logic [VW-1:0]      rd_idx,
  input  logic [1:0]         rd_dw,
  output logic [31:0]        rd_data,
  input  logic [VW-1:0]      sel_idx,
  output msix_msg_t          sel_msg,
  output logic [NUM_VEC-1:0] mask_o
);
  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      case (wr_dw)
        2'd0: lo_q[wr_idx]   <= wr_data;
        2'd1: hi_q[wr_idx]   <= wr_data;
        2'd2: dat_q[wr_idx]  <= wr_data;
        default: mask_q[wr_idx] <= wr_data[0];
      endcase
    end
  end

  always_comb begin
    case (rd_dw)
      2'd0:    rd_data = lo_q[rd_idx];
      2'd1:    rd_data = hi_q[rd_idx];
      2'd2:    rd_data = dat_q[rd_idx];
      default: rd_data = {31'd0, mask_q[rd_idx]};
    endcase
  end

  assign sel_msg.addr = {hi_q[sel_idx], lo_q[sel_idx]};
  assign sel_msg.data = dat_q[sel_idx];
  assign mask_o       = mask_q;

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int VW      = $clog2(NUM_VEC),
  parameter int NQW     = (NUM_VEC + QW_BITS - 1) / QW_BITS,
  parameter int QW_W    = (NQW > 1) ? $clog2(NQW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VW-1:0]      set_idx,
  input  logic               clr_en,
  input  logic [VW-1:0]      clr_idx,
  input  logic [QW_W-1:0]    rd_qw,
  output logic [63:0]        rd_qword,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0]     pend_q;
  logic [NUM_VEC-1:0]     set_mask;
  logic [NUM_VEC-1:0]     clr_mask;
  logic [NQW*QW_BITS-1:0] padded;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      set_mask[i] = set_en && (set_idx == VW'(i));
      clr_mask[i] = clr_en && (clr_idx == VW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  assign padded   = (NQW*QW_BITS)'(pend_q);
  assign rd_qword = padded[rd_qw*QW_BITS +: QW_BITS];
  assign pend_o   = pend_q;

  // R10
  pend_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> ($countones(pend_q) <= $countones($past(pend_q))));
endmodule

// File: rtl/msix_pick.sv
module msix_pick #(
  parameter int NUM_VEC = 64,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] elig,
  output logic               grant_valid,
  output logic [VW-1:0]      grant_idx
);
  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant_valid = 1'b1;
        grant_idx   = VW'(i);
      end
    end
  end
endmodule

// File: rtl/msix_engine.sv
module msix_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int ADDR_W  = 16,
  parameter int PBA_OFF = 32'h2000,
  localparam int VW     = $clog2(NUM_VEC),
  localparam int NQW    = (NUM_VEC + QW_BITS - 1) / QW_BITS,
  localparam int QW_W   = (NQW > 1) ? $clog2(NQW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              evt_valid,
  input  logic [VW-1:0]     evt_vec,
  input  logic              vec_enable,
  input  logic              func_mask,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic [VW-1:0]     msg_vec
);
  localparam int TAB_BYTES = NUM_VEC * ENTRY_BYTES;
  localparam int PBA_BYTES = NQW * 8;

  logic               tab_hit, pba_hit;
  logic [31:0]        addr32, pba_rel;
  logic [VW-1:0]      tab_idx;
  logic [QW_W-1:0]    pba_qw;
  logic [31:0]        tab_rd;
  logic [63:0]        pba_rd;
  logic [NUM_VEC-1:0] mask_v, pend_v, elig;
  logic               grant_valid, send_ok, load, evt_ok;
  logic [VW-1:0]      grant_idx;
  msix_msg_t          sel_msg;

  // host decode
  assign addr32  = 32'(host_addr);
  assign tab_hit = addr32 < 32'(TAB_BYTES);
  assign pba_rel = addr32 - 32'(PBA_OFF);
  assign pba_hit = (addr32 >= 32'(PBA_OFF)) && (pba_rel < 32'(PBA_BYTES));
  assign tab_idx = host_addr[4 +: VW];
  assign pba_qw  = QW_W'(pba_rel >> 3);

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VW(VW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_en && tab_hit),
    .wr_idx  (tab_idx),
    .wr_dw   (host_addr[3:2]),
    .wr_data (host_wdata),
    .rd_idx  (tab_idx),
    .rd_dw   (host_addr[3:2]),
    .rd_data (tab_rd),
    .sel_idx (grant_idx),
    .sel_msg (sel_msg),
    .mask_o  (mask_v)
  );

  assign evt_ok = evt_valid && (32'(evt_vec) < 32'(NUM_VEC));

  msix_pend_array #(.NUM_VEC(NUM_VEC), .VW(VW), .NQW(NQW), .QW_W(QW_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (evt_ok),
    .set_idx  (evt_vec),
    .clr_en   (load),
    .clr_idx  (grant_idx),
    .rd_qw    (pba_qw),
    .rd_qword (pba_rd),
    .pend_o   (pend_v)
  );

  assign elig = pend_v & ~mask_v;

  msix_pick #(.NUM_VEC(NUM_VEC), .VW(VW)) u_pick (
    .elig        (elig),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
  );

  assign send_ok = vec_enable && !func_mask;
  assign load    = grant_valid && send_ok && (!msg_valid || msg_ready);

  // output request register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= sel_msg.addr;
      msg_data  <= sel_msg.data;
      msg_vec   <= grant_idx;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // host read data register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd_en) begin
      if (tab_hit)      host_rdata <= tab_rd;
      else if (pba_hit) host_rdata <= pba_rel[2] ? pba_rd[63:32] : pba_rd[31:0];
      else              host_rdata <= '0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) &&
                                $stable(msg_data) && $stable(msg_vec));

  // R6
  send_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(vec_enable && !func_mask));
endmodule

// File: tb/msix_engine_bench.sv
module msix_engine_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 72;
  localparam int VW    = $clog2(NV);
  localparam int PBA   = 32'h2000;

  logic clk = 0, rst_n = 0;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic evt_valid = 0;
  logic [VW-1:0] evt_vec = '0;
  logic vec_enable = 1, func_mask = 0, msg_ready = 1;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [VW-1:0] msg_vec;

  int total = 0, bad = 0, cap_n = 0;
  logic [VW-1:0] cap_vec  [0:127];
  logic [63:0]   cap_addr [0:127];
  logic [31:0]   cap_data [0:127];
  logic [31:0]   rd;

  always #(CLK_P/2) clk = ~clk;

  msix_engine #(.NUM_VEC(NV), .ADDR_W(16), .PBA_OFF(PBA)) u_msix_engine (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_valid(evt_valid), .evt_vec(evt_vec), .vec_enable(vec_enable),
    .func_mask(func_mask), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec));

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (cap_n < 128) begin
        cap_vec[cap_n]  <= msg_vec;
        cap_addr[cap_n] <= msg_addr;
        cap_data[cap_n] <= msg_data;
      end
      cap_n <= cap_n + 1;
    end
  end

  function automatic logic [63:0] exp_addr(int v);
    return {32'hA500_0000 + 32'(v), 32'h1000_0000 + 32'(v) * 16};
  endfunction
  function automatic logic [31:0] exp_data(int v);
    return 32'h0000_C000 + 32'(v);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_addr = 16'(a); host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic hrd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1; host_addr = 16'(a);
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  task automatic fire(input int v);
    @(negedge clk);
    evt_valid = 1; evt_vec = VW'(v);
    @(negedge clk);
    evt_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    ticks(3);
    rst_n = 1;
    ticks(1);
    // R1 reset state
    chk("R1 valid", 64'(msg_valid), 64'd0);
    hrd(16*0 + 12, rd);  chk("R1 mask v0", 64'(rd), 64'd1);
    hrd(16*71 + 12, rd); chk("R1 mask v71", 64'(rd), 64'd1);
    hrd(PBA, rd);        chk("R1 pend qw0", 64'(rd), 64'd0);
    hrd(PBA + 8, rd);    chk("R1 pend qw1", 64'(rd), 64'd0);

    // R2 program table
    for (int v = 0; v < NV; v++) begin
      hwr(16*v + 0, exp_addr(v)[31:0]);
      hwr(16*v + 4, exp_addr(v)[63:32]);
      hwr(16*v + 8, exp_data(v));
    end
    hrd(16*3 + 0, rd); chk("R2 lo", 64'(rd), 64'(exp_addr(3)[31:0]));
    hrd(16*3 + 4, rd); chk("R2 hi", 64'(rd), 64'(exp_addr(3)[63:32]));
    hrd(16*3 + 8, rd); chk("R2 data", 64'(rd), 64'(exp_data(3)));
    hwr(16*5 + 12, 32'hFFFF_FFFE);
    hrd(16*5 + 12, rd); chk("R2 ctrl bit0 only", 64'(rd), 64'd0);
    for (int v = 0; v < NV; v++) hwr(16*v + 12, 32'd0);

    // R3 latency on vector 0
    fire(0);
    chk("R3 not yet", 64'(msg_valid), 64'd0);
    ticks(1);
    chk("R3 valid", 64'(msg_valid), 64'd1);
    ticks(2);
    chk("R3 count v0", 64'(cap_n), 64'd1);
    chk("R3 vec v0", 64'(cap_vec[0]), 64'd0);
    // R3 sweep every vector
    for (int v = 1; v < NV; v++) begin
      fire(v);
      ticks(3);
      chk("R3 count", 64'(cap_n), 64'(v + 1));
      chk("R3 vec", 64'(cap_vec[v]), 64'(v));
      chk("R3 addr", cap_addr[v], exp_addr(v));
      chk("R3 data", 64'(cap_data[v]), 64'(exp_data(v)));
    end

    // R4 masked events
    for (int v = 0; v < NV; v++) hwr(16*v + 12, 32'd1);
    base = cap_n;
    fire(2); fire(63); fire(64); fire(70);
    fire(63); // R9 repeat event merges
    ticks(4);
    chk("R4 no message", 64'(cap_n), 64'(base));
    hrd(PBA + 0, rd);  chk("R4 qw0 lo", 64'(rd), 64'h4);
    hrd(PBA + 4, rd);  chk("R4 qw0 hi", 64'(rd), 64'h8000_0000);
    hrd(PBA + 8, rd);  chk("R4 qw1 lo", 64'(rd), 64'h41);

    // R10 writes to owed array ignored, unmapped reads zero
    hwr(PBA + 0, 32'hFFFF_FFFF);
    hrd(PBA + 0, rd);  chk("R10 pba write ignored", 64'(rd), 64'h4);
    hrd(16'h1000, rd); chk("R10 unmapped", 64'(rd), 64'd0);
    chk("R10 no message", 64'(cap_n), 64'(base));

    // R5 unmask replays, R9 only once
    hwr(16*63 + 12, 32'd0);
    ticks(6);
    chk("R9 one message", 64'(cap_n), 64'(base + 1));
    chk("R5 vec", 64'(cap_vec[base]), 64'd63);
    chk("R5 addr", cap_addr[base], exp_addr(63));
    hrd(PBA + 4, rd);  chk("R5 pend cleared", 64'(rd), 64'd0);

    // R6 function mask and enable hold back
    func_mask = 1;
    hwr(16*2 + 12, 32'd0);  hwr(16*10 + 12, 32'd0);
    hwr(16*64 + 12, 32'd0); hwr(16*70 + 12, 32'd0);
    fire(10);
    ticks(4);
    base = cap_n;
    chk("R6 fmask holds", 64'(msg_valid), 64'd0);
    hrd(PBA + 0, rd);  chk("R6 pend set", 64'(rd), 64'h404);
    @(negedge clk); vec_enable = 0; func_mask = 0;
    ticks(4);
    chk("R6 enable holds", 64'(msg_valid), 64'd0);
    @(negedge clk); msg_ready = 0; vec_enable = 1;
    ticks(3);
    chk("R7 first lowest", 64'(msg_vec), 64'd2);
    for (int k = 0; k < 4; k++) begin
      ticks(1);
      chk("R8 valid held", 64'(msg_valid), 64'd1);
      chk("R8 vec held", 64'(msg_vec), 64'd2);
      chk("R8 addr held", msg_addr, exp_addr(2));
    end
    @(negedge clk); msg_ready = 1;
    ticks(10);
    chk("R8 count", 64'(cap_n), 64'(base + 4));
    chk("R7 order 0", 64'(cap_vec[base + 0]), 64'd2);
    chk("R7 order 1", 64'(cap_vec[base + 1]), 64'd10);
    chk("R7 order 2", 64'(cap_vec[base + 2]), 64'd64);
    chk("R7 order 3", 64'(cap_vec[base + 3]), 64'd70);
    chk("R6 data", 64'(cap_data[base + 3]), 64'(exp_data(70)));
    hrd(PBA + 0, rd);  chk("R5 qw0 empty", 64'(rd), 64'd0);
    hrd(PBA + 8, rd);  chk("R5 qw1 empty", 64'(rd), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule